// File: doc/BRIEF.md
# Three-Channel Fly-By Peripheral DMA Engine

This block is a bus-master DMA engine that moves data between system memory and three peripherals: a USB function (channel 0), an infrared link (channel 1) and an audio output (channel 2). Each channel has its own memory address register, remaining-word counter, enable bit and direction bit. Software loads these through a simple load port. A peripheral starts the work by raising its request line. The engine then picks one pending channel, asks the system bus for mastership, and keeps the bus locked until that channel's transaction is complete.

Transfers are fly-by. During each beat the engine drives the memory address and a per-channel acknowledge strobe together, so the peripheral supplies or sinks the word directly. The data never passes through the engine. The USB channel moves up to four words per transaction. The other two channels move one word each. The audio channel always reads memory and writes to the peripheral.

Top module: `flyby_dma`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `bus_req`, `bus_lock`, `bus_valid`, `pdack`, `done` and `err` are all 0.
- R2: `bus_req` stays low unless some channel has its request high, is enabled, and has a nonzero word count. A request seen at a clock edge raises `bus_req` in the cycle after that edge.
- R3: Once granted, `bus_lock` and `bus_req` stay high until the last beat of the transaction. Both fall in the cycle after that beat.
- R4: One transaction moves min(4, remaining) words on channel 0. On channels 1 and 2 it moves one word.
- R5: Each beat puts the channel's current address on `bus_addr`. The address then advances by 4 and the count drops by 1. When the count reaches 0, `done[i]` is set. That channel then raises no further requests until it is reloaded, and reloading clears `done[i]`.
- R6: When several channels are pending, channel 0 wins over channel 1, and channel 1 wins over channel 2.
- R7: On channels 0 and 1, `bus_write` during a beat equals the loaded direction bit (1 = peripheral to memory). On channel 2, `bus_write` is always 0.
- R8: A channel loaded with its enable bit at 0 ignores its request line: no bus request, no beat, no `done`.
- R9: If `bus_grant` drops mid-transaction, `err` is set and stays set until the next load. No beat occurs while grant is low. `bus_lock` and `bus_req` stay high, and the burst resumes at the next address when grant returns.
- R10: `bus_valid` is high only while `bus_grant` and `bus_lock` are both high. During a beat, `pdack` is one-hot, with bit i naming the channel served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | 3 | Peripheral transfer requests, bit i = channel i |
| cfg_we | input | 1 | Load strobe for the selected channel; also clears `err` |
| cfg_sel | input | 2 | Channel to load |
| cfg_addr | input | AW | Start memory address |
| cfg_words | input | CW | Number of words to move |
| cfg_en | input | 1 | Channel enable |
| cfg_dir | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| bus_grant | input | 1 | Bus mastership grant from the system arbiter |
| bus_req | output | 1 | Bus mastership request |
| bus_lock | output | 1 | Engine owns the bus for the current transaction |
| bus_valid | output | 1 | A word beat completes at the next clock edge |
| bus_addr | output | AW | Memory address of the current beat |
| bus_write | output | 1 | Memory write (1) or read (0) for the current beat |
| pdack | output | 3 | Per-channel peripheral acknowledge during a beat |
| done | output | 3 | Sticky per-channel completion flags |
| err | output | 1 | Sticky flag: grant lost mid-transaction |

## Verification
The bench builds the block with AW = 32 and CW = 16. Word counts are kept small: 6, 4, 2 and 1. With these values, a USB channel finishes one full four-word burst followed by a short two-word burst, so both the burst cap and the early end on an exhausted count are exercised. Loading all three channels at once with one-word and four-word counts shows the priority order in a single run of six beats. A withdrawn grant after two beats of a four-word burst exposes the locked hold and the resume at the next address.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    localparam int NCH       = 3;
    localparam int CH_USB    = 0;
    localparam int CH_IR     = 1;
    localparam int CH_SND    = 2;
    localparam int USB_BURST = 4;

    typedef logic [1:0] ch_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER
    } dma_state_e;

    typedef struct packed {
        logic    found;
        ch_idx_t idx;
    } arb_res_t;

    function automatic logic [2:0] burst_len(ch_idx_t ch);
        return (ch == ch_idx_t'(CH_USB)) ? 3'(USB_BURST) : 3'd1;
    endfunction

endpackage

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
    import flyby_dma_pkg::*;
#(
    parameter int   AW         = 32,
    parameter int   CW         = 16,
    parameter logic FORCE_READ = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_words,
    input  logic          ld_en,
    input  logic          ld_dir,
    input  logic          dreq,
    input  logic          step,
    output logic          pend,
    output logic [AW-1:0] addr,
    output logic          dir,
    output logic          last,
    output logic          done
);
    localparam logic DIR_OK = !FORCE_READ;

    logic [CW-1:0] words;
    logic          en;

    assign pend = en && dreq && (words != '0);
    assign last = (words == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            words <= '0;
            en    <= 1'b0;
            dir   <= 1'b0;
            done  <= 1'b0;
        end else if (load) begin
            addr  <= ld_addr;
            words <= ld_words;
            en    <= ld_en;
            dir   <= ld_dir & DIR_OK;
            done  <= 1'b0;
        end else if (step) begin
            addr  <= addr + AW'(4);
            words <= words - CW'(1);
            if (last) done <= 1'b1;
        end
    end

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        step && !load |=> addr == $past(addr) + AW'(4));

    assert_done_set_R5: assert property (@(posedge clk) disable iff (rst)
        step && !load && last |=> done);

endmodule

// File: rtl/flyby_dma_arb.sv
module flyby_dma_arb
    import flyby_dma_pkg::*;
(
    input  logic [NCH-1:0] pend,
    output arb_res_t       res
);
    always_comb begin
        res = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                res.found = 1'b1;
                res.idx   = ch_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
    import flyby_dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  arb_res_t       arb,
    input  logic           grant,
    input  logic [NCH-1:0] last_vec,
    input  logic           clr_err,
    output dma_state_e     state,
    output ch_idx_t        cur,
    output logic           step,
    output logic           err
);
    logic [2:0] beat_cnt;
    logic       burst_end;

    assign step      = (state == ST_XFER) && grant;
    assign burst_end = (beat_cnt == burst_len(cur) - 3'd1) || last_vec[cur];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            beat_cnt <= '0;
            err      <= 1'b0;
        end else begin
            if (clr_err)
                err <= 1'b0;
            else if (state == ST_XFER && !grant)
                err <= 1'b1;
            case (state)
                ST_IDLE: if (arb.found) begin
                    cur   <= arb.idx;
                    state <= ST_REQ;
                end
                ST_REQ: if (grant) begin
                    state    <= ST_XFER;
                    beat_cnt <= '0;
                end
                ST_XFER: if (grant) begin
                    beat_cnt <= beat_cnt + 3'd1;
                    if (burst_end) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_burst_cap_R4: assert property (@(posedge clk) disable iff (rst)
        state == ST_XFER |-> beat_cnt < burst_len(cur));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        state == ST_XFER && !grant && !clr_err |=> err);

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] dreq,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [CW-1:0]  cfg_words,
    input  logic           cfg_en,
    input  logic           cfg_dir,
    input  logic           bus_grant,
    output logic           bus_req,
    output logic           bus_lock,
    output logic           bus_valid,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_write,
    output logic [NCH-1:0] pdack,
    output logic [NCH-1:0] done,
    output logic           err
);
    logic [NCH-1:0] pend_vec, last_vec, dir_vec;
    logic [AW-1:0]  ch_addr [NCH];
    arb_res_t       arb;
    dma_state_e     state;
    ch_idx_t        cur;
    logic           step;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        flyby_dma_chan #(
            .AW(AW), .CW(CW), .FORCE_READ(i == CH_SND)
        ) chan_i (
            .clk(clk), .rst(rst),
            .load(cfg_we && cfg_sel == ch_idx_t'(i)),
            .ld_addr(cfg_addr), .ld_words(cfg_words),
            .ld_en(cfg_en), .ld_dir(cfg_dir),
            .dreq(dreq[i]),
            .step(step && cur == ch_idx_t'(i)),
            .pend(pend_vec[i]), .addr(ch_addr[i]), .dir(dir_vec[i]),
            .last(last_vec[i]), .done(done[i])
        );
    end

    flyby_dma_arb arb_i (.pend(pend_vec), .res(arb));

    flyby_dma_ctrl ctrl_i (
        .clk(clk), .rst(rst), .arb(arb), .grant(bus_grant),
        .last_vec(last_vec), .clr_err(cfg_we),
        .state(state), .cur(cur), .step(step), .err(err)
    );

    assign bus_req   = (state != ST_IDLE);
    assign bus_lock  = (state == ST_XFER);
    assign bus_valid = step;
    assign bus_write = step && dir_vec[cur];

    always_comb begin
        bus_addr = '0;
        pdack    = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cur == ch_idx_t'(i)) bus_addr = ch_addr[i];
            pdack[i] = step && cur == ch_idx_t'(i);
        end
    end

    assert_req_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(|pend_vec));

    assert_lock_release_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_lock) |-> $past(bus_valid));

    assert_valid_grant_R10: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_grant && bus_lock && $onehot(pdack));

    assert_snd_read_R7: assert property (@(posedge clk) disable iff (rst)
        bus_valid && pdack[CH_SND] |-> !bus_write);

endmodule

// File: tb/flyby_dma_tb.sv
module flyby_dma_tb_top;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    dreq = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_words = '0;
    logic          cfg_en = 1'b0;
    logic          cfg_dir = 1'b0;
    logic          bus_grant = 1'b0;
    logic          bus_req, bus_lock, bus_valid, bus_write, err;
    logic [AW-1:0] bus_addr;
    logic [2:0]    pdack, done;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] b_addr [64];
    logic [2:0]    b_ack  [64];
    logic          b_wr   [64];
    int            nb = 0;

    flyby_dma #(.AW(AW), .CW(CW)) dut_i (.*);

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (bus_valid && nb < 64) begin
            b_addr[nb] = bus_addr;
            b_ack[nb]  = pdack;
            b_wr[nb]   = bus_write;
            nb = nb + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic load(input int ch, input logic [31:0] a, input int w, input logic en, input logic dir);
        tick();
        cfg_we = 1'b1; cfg_sel = 2'(ch); cfg_addr = a;
        cfg_words = CW'(w); cfg_en = en; cfg_dir = dir;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic check_beat(input int idx, input logic [31:0] a, input logic [2:0] ack, input logic wr, input string req);
        chk(b_addr[idx] == a, req, b_addr[idx], a);
        chk(b_ack[idx] == ack, req, 32'(b_ack[idx]), 32'(ack));
        chk(b_wr[idx] == wr, req, 32'(b_wr[idx]), 32'(wr));
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk({bus_req, bus_lock, bus_valid, pdack, done, err} == '0, "R1 in reset",
            32'({bus_req, bus_lock, bus_valid, pdack, done, err}), 0);
        tick(); rst = 1'b0;
        @(negedge clk);
        chk({bus_req, bus_lock, bus_valid, pdack, done, err} == '0, "R1 after release",
            32'({bus_req, bus_lock, bus_valid, pdack, done, err}), 0);
    endtask

    task automatic test_usb();
        int base;
        load(0, 32'h100, 6, 1'b1, 1'b1);
        bus_grant = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(bus_req == 1'b0, "R2 idle without request", 32'(bus_req), 0);
        end
        // first burst: four words
        base = nb;
        tick(); dreq = 3'b001;
        @(negedge clk);
        chk(bus_req == 1'b0, "R2 same cycle", 32'(bus_req), 0);
        @(negedge clk);
        chk(bus_req == 1'b1, "R2 one cycle later", 32'(bus_req), 1);
        tick(); dreq = 3'b000;
        repeat (8) @(negedge clk);
        chk(nb - base == 4, "R4 usb burst of four", 32'(nb - base), 4);
        for (int k = 0; k < 4; k++)
            check_beat(base + k, 32'h100 + 32'(4 * k), 3'b001, 1'b1, "R5 R7 R10 usb beat");
        chk(done[0] == 1'b0, "R5 not done yet", 32'(done[0]), 0);
        chk(bus_lock == 1'b0 && bus_req == 1'b0, "R3 released", 32'({bus_lock, bus_req}), 0);
        // second burst: remaining two words
        base = nb;
        tick(); dreq = 3'b001;
        repeat (2) @(negedge clk);
        tick(); dreq = 3'b000;
        repeat (8) @(negedge clk);
        chk(nb - base == 2, "R4 short usb burst", 32'(nb - base), 2);
        check_beat(base, 32'h110, 3'b001, 1'b1, "R5 usb beat");
        check_beat(base + 1, 32'h114, 3'b001, 1'b1, "R5 usb beat");
        chk(done[0] == 1'b1, "R5 done set", 32'(done[0]), 1);
        // exhausted channel stays quiet
        tick(); dreq = 3'b001;
        repeat (5) begin
            @(negedge clk);
            chk(bus_req == 1'b0, "R5 no request after done", 32'(bus_req), 0);
        end
        tick(); dreq = 3'b000;
    endtask

    task automatic test_prio();
        int base;
        load(0, 32'h200, 4, 1'b1, 1'b1);
        load(1, 32'h300, 1, 1'b1, 1'b0);
        load(2, 32'h400, 1, 1'b1, 1'b1);
        base = nb;
        tick(); dreq = 3'b111;
        repeat (20) @(negedge clk);
        tick(); dreq = 3'b000;
        chk(nb - base == 6, "R6 beat total", 32'(nb - base), 6);
        for (int k = 0; k < 4; k++)
            check_beat(base + k, 32'h200 + 32'(4 * k), 3'b001, 1'b1, "R6 usb first");
        check_beat(base + 4, 32'h300, 3'b010, 1'b0, "R6 infrared second");
        check_beat(base + 5, 32'h400, 3'b100, 1'b0, "R6 R7 sound last, forced read");
        chk(done == 3'b111, "R5 all done", 32'(done), 32'h7);
        @(negedge clk);
        chk(bus_req == 1'b0, "R5 quiet after all done", 32'(bus_req), 0);
    endtask

    task automatic test_enable();
        int base;
        logic seen = 1'b0;
        load(1, 32'h500, 2, 1'b0, 1'b0);
        base = nb;
        tick(); dreq = 3'b010;
        repeat (10) begin
            @(negedge clk);
            if (bus_req) seen = 1'b1;
        end
        tick(); dreq = 3'b000;
        chk(seen == 1'b0, "R8 disabled no request", 32'(seen), 0);
        chk(nb == base, "R8 disabled no beat", 32'(nb - base), 0);
        chk(done[1] == 1'b0, "R8 disabled not done", 32'(done[1]), 0);
    endtask

    task automatic test_grant_loss();
        int base;
        int guard = 0;
        load(0, 32'h600, 4, 1'b1, 1'b0);
        chk(err == 1'b0, "R9 err clear before", 32'(err), 0);
        bus_grant = 1'b1;
        base = nb;
        tick(); dreq = 3'b001;
        tick(); dreq = 3'b000;
        while (nb - base < 2 && guard < 20) begin
            tick(); guard++;
        end
        bus_grant = 1'b0;
        repeat (4) @(negedge clk);
        chk(nb - base == 2, "R9 no beat without grant", 32'(nb - base), 2);
        chk(bus_lock == 1'b1 && bus_req == 1'b1, "R9 R3 still held", 32'({bus_lock, bus_req}), 3);
        chk(err == 1'b1, "R9 err set", 32'(err), 1);
        tick(); bus_grant = 1'b1;
        repeat (6) @(negedge clk);
        chk(nb - base == 4, "R9 resumes to four", 32'(nb - base), 4);
        for (int k = 0; k < 4; k++)
            check_beat(base + k, 32'h600 + 32'(4 * k), 3'b001, 1'b0, "R9 R7 addr continuity");
        chk(err == 1'b1, "R9 err sticky", 32'(err), 1);
        chk(bus_lock == 1'b0, "R3 released after resume", 32'(bus_lock), 0);
        load(2, 32'h700, 1, 1'b0, 1'b0);
        @(negedge clk);
        chk(err == 1'b0, "R9 err cleared by load", 32'(err), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        test_reset();
        test_usb();
        test_prio();
        test_enable();
        test_grant_loss();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
        finish_run();
    end
endmodule